// File: doc/BRIEF.md
# Selectable-Length Buffered PWM Channel

This block is one pulse-width modulation channel. A free-running counter advances once per count strobe. A length field chooses a cycle of 9, 10 or 11 bits. The output goes high when the low N bits of the counter reach the live compare value. It goes low when the N-bit cycle wraps. A shadow reload register holds the next duty value, and the block copies it into the live compare at every wrap. Software can therefore change the duty without glitches.

Software reaches the block through a small byte-wide register port. A bank bit in the control register decides whether the low-byte and high-byte locations reach the shadow register or the live compare. The duty value is right-justified across the two bytes. A low-byte write clears the compare enable, and a high-byte write sets it. A two-byte update therefore leaves the channel off until the second byte lands, and a lone low-byte write gives 0% duty. Sticky match and overflow flags record the two edges of the waveform.

Top module: `pwm_reload_chan`

## Requirements
- R1: After reset the output is low, both flags are 0, and every register reads 0: control (address 0), value low byte (address 1) and value high byte (address 2).
- R2: Control bits [5:4] select the cycle length N: 1 gives 9 bits, 2 gives 10 bits and 3 gives 11 bits. The output rises once every 2^N count strobes.
- R3: With compare value C below 2^N, the output is high for exactly 2^N − C strobes of each cycle. C = 0 gives a permanently high output. A C with any bit at position N or above never matches, so the output stays low.
- R4: The output rises only on the strobe that brings the low N counter bits equal to the live compare, which is counter value C within the cycle. It falls only on the wrap, when the enable clears, or when the length field is 0.
- R5: On every wrap, the shadow reload value is copied into the live compare register.
- R6: Control bit 7 selects the bank: 1 reaches the shadow reload register, 0 reaches the live compare. Address 1 holds value bits [7:0]. Address 2 holds value bits [10:8] in data bits [2:0], and its upper bits read as 0.
- R7: A write to address 1 clears the compare enable, and a write to address 2 sets it. The enable reads at control bit 2 and ignores control writes. While it is 0, the output is low from the second clock edge on and the match flag is not set.
- R8: With the match-flag enable (control bit 3) at 1, each output rise sets the match flag (control bit 0). With the enable at 0, the flag is not set.
- R9: Every wrap of the N-bit cycle sets the overflow flag (control bit 1).
- R10: Both flags are sticky. A control write with 0 in a flag's bit clears that flag. A 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R11: With length field 0, the output stays low, neither flag is set, and no reload takes place, though the counter keeps running.
- R12: With the count strobe low, the counter holds, so the output and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count strobe; the counter advances by one in each cycle it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 control, 1 value low, 2 value high) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `addr` stays within the three decoded locations. They also assume that the flags are cleared only through control writes, and that no write changes the length field in the cycle of a wrap. The bench drives every register access through one write task, which changes inputs only on falling edges. It brings all stimulus through the port and changes the length only before it waits for a fresh wrap. Sticky-flag clears are done with counting stopped, so no wrap can coincide with the clear in those checks.

// File: rtl/pwm_reload_pkg.sv
// Package: shared constants for the buffered PWM channel.
// Assumes an 8-bit register port and at most 16-bit duty values.
package pwm_reload_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 2;

    // Register locations
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_VAL_LO = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_VAL_HI = 3'd2;

    // Control register bit positions
    localparam int CTRL_MAT_BIT  = 0;
    localparam int CTRL_OVF_BIT  = 1;
    localparam int CTRL_ENA_BIT  = 2;
    localparam int CTRL_MIE_BIT  = 3;
    localparam int CTRL_LEN_LSB  = 4;
    localparam int CTRL_BANK_BIT = 7;

    // Control fields that software writes
    typedef struct packed {
        logic             bank;
        logic [SEL_W-1:0] len;
        logic             mie;
    } ctrl_t;
endpackage

// File: rtl/pwm_tbase.sv
// Module: pwm_tbase
// Free-running counter with a selectable wrap length. Flags the wrap of
// the active N-bit cycle and presents the masked next count value.
// Assumes length code 0 is idle, and codes 1..3 add 1..3 bits to a base
// of CNT_W-3 bits.
module pwm_tbase #(
    parameter int CNT_W = 11,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [SEL_W-1:0] len_sel,
    output logic [CNT_W-1:0] next_low,
    output logic             ovf_evt,
    output logic             len_valid
);
    localparam int BASE_LEN = CNT_W - ((2 ** SEL_W) - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] len_mask;
    logic             wrap;

    // Mask of the active cycle bits, one bit per counter position
    generate
        for (genvar b = 0; b < CNT_W; b++) begin : g_mask
            if (b < BASE_LEN) begin : g_base
                assign len_mask[b] = 1'b1;
            end else begin : g_ext
                assign len_mask[b] = (len_sel > SEL_W'(b - BASE_LEN));
            end
        end
    endgenerate

    // Counter: advance on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_en) begin
            cnt_q <= cnt_inc;
        end
    end

    // Wrap detection and next-value presentation
    always_comb begin
        cnt_inc   = cnt_q + CNT_W'(1);
        wrap      = ((cnt_q & len_mask) == len_mask);
        len_valid = (len_sel != '0);
        ovf_evt   = cnt_en && len_valid && wrap;
        next_low  = cnt_inc & len_mask;
    end
endmodule

// File: rtl/pwm_outstage.sv
// Module: pwm_outstage
// Output flip-flop: set on compare match, cleared on wrap. Held low
// while the compare enable is off or the length is idle.
// Assumes cmp_next already holds the reloaded value in a wrap cycle.
module pwm_outstage #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             len_valid,
    input  logic             cmp_en,
    input  logic             ovf_evt,
    input  logic [CNT_W-1:0] next_low,
    input  logic [CNT_W-1:0] cmp_next,
    output logic             match_evt,
    output logic             pwm_out
);
    // Match: the count about to be entered equals the compare value
    always_comb begin
        match_evt = tick && len_valid && cmp_en && (next_low == cmp_next);
    end

    // Output: a match takes precedence over a wrap in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= 1'b0;
        end else if (!cmp_en || !len_valid) begin
            pwm_out <= 1'b0;
        end else if (match_evt) begin
            pwm_out <= 1'b1;
        end else if (ovf_evt) begin
            pwm_out <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Register file: control, sticky flags, compare enable, and the live
// compare and shadow reload pair behind a bank select.
// Assumes CNT_W lies between BYTE_W+1 and 2*BYTE_W.
module pwm_regs
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ovf_evt,
    input  logic              match_evt,
    output logic [BYTE_W-1:0] rdata,
    output logic [SEL_W-1:0]  len_sel,
    output logic              match_ie,
    output logic              cmp_en,
    output logic              match_flag,
    output logic              ovf_flag,
    output logic [CNT_W-1:0]  cmp_next
);
    localparam int HI_W = CNT_W - BYTE_W;

    ctrl_t            ctrl_q;
    logic             ena_q;
    logic             mflag_q;
    logic             oflag_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] cmp_d;
    logic [CNT_W-1:0] rld_d;
    logic [CNT_W-1:0] sel_val;
    logic             wr_ctrl;
    logic             wr_lo;
    logic             wr_hi;

    // Address decode
    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_CTRL);
        wr_lo   = wr_en && (addr == ADDR_VAL_LO);
        wr_hi   = wr_en && (addr == ADDR_VAL_HI);
    end

    // Control fields written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.bank <= wdata[CTRL_BANK_BIT];
            ctrl_q.len  <= wdata[CTRL_LEN_LSB +: SEL_W];
            ctrl_q.mie  <= wdata[CTRL_MIE_BIT];
        end
    end

    // Sticky flags: write 0 to clear, a set event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mflag_q <= 1'b0;
            oflag_q <= 1'b0;
        end else begin
            mflag_q <= (mflag_q && !(wr_ctrl && !wdata[CTRL_MAT_BIT]))
                       || (match_evt && ctrl_q.mie);
            oflag_q <= (oflag_q && !(wr_ctrl && !wdata[CTRL_OVF_BIT]))
                       || ovf_evt;
        end
    end

    // Compare enable: the low-byte write clears it, the high-byte write sets it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= 1'b0;
        end else if (wr_lo) begin
            ena_q <= 1'b0;
        end else if (wr_hi) begin
            ena_q <= 1'b1;
        end
    end

    // Next live compare and reload values: reload on wrap, then byte writes
    always_comb begin
        cmp_next = ovf_evt ? rld_q : cmp_q;
        cmp_d    = cmp_next;
        rld_d    = rld_q;
        if (wr_lo) begin
            if (ctrl_q.bank) rld_d[BYTE_W-1:0] = wdata;
            else             cmp_d[BYTE_W-1:0] = wdata;
        end
        if (wr_hi) begin
            if (ctrl_q.bank) rld_d[CNT_W-1:BYTE_W] = wdata[HI_W-1:0];
            else             cmp_d[CNT_W-1:BYTE_W] = wdata[HI_W-1:0];
        end
    end

    // Value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            rld_q <= '0;
        end else begin
            cmp_q <= cmp_d;
            rld_q <= rld_d;
        end
    end

    // Read multiplexer
    always_comb begin
        sel_val = ctrl_q.bank ? rld_q : cmp_q;
        rdata   = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[CTRL_BANK_BIT]              = ctrl_q.bank;
                rdata[CTRL_LEN_LSB +: SEL_W]      = ctrl_q.len;
                rdata[CTRL_MIE_BIT]               = ctrl_q.mie;
                rdata[CTRL_ENA_BIT]               = ena_q;
                rdata[CTRL_OVF_BIT]               = oflag_q;
                rdata[CTRL_MAT_BIT]               = mflag_q;
            end
            ADDR_VAL_LO: rdata = sel_val[BYTE_W-1:0];
            ADDR_VAL_HI: rdata = BYTE_W'(sel_val[CNT_W-1:BYTE_W]);
            default:     rdata = '0;
        endcase
    end

    // Outputs to the other stages
    always_comb begin
        len_sel    = ctrl_q.len;
        match_ie   = ctrl_q.mie;
        cmp_en     = ena_q;
        match_flag = mflag_q;
        ovf_flag   = oflag_q;
    end
endmodule

// File: rtl/pwm_reload_chan.sv
// Module: pwm_reload_chan
// Top level of the buffered PWM channel: time base, register file and
// output stage. Assumes a single clock domain, with the count strobe and
// the register port synchronous to clk.
module pwm_reload_chan
    import pwm_reload_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              pwm_out,
    output logic              match_flag,
    output logic              ovf_flag
);
    logic [SEL_W-1:0] len_sel;
    logic             len_valid;
    logic             match_ie;
    logic             cmp_en;
    logic             ovf_evt;
    logic             match_evt;
    logic [CNT_W-1:0] next_low;
    logic [CNT_W-1:0] cmp_next;

    // Counter and wrap detection
    pwm_tbase #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .len_sel   (len_sel),
        .next_low  (next_low),
        .ovf_evt   (ovf_evt),
        .len_valid (len_valid)
    );

    // Software-visible registers
    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .ovf_evt    (ovf_evt),
        .match_evt  (match_evt),
        .rdata      (rdata),
        .len_sel    (len_sel),
        .match_ie   (match_ie),
        .cmp_en     (cmp_en),
        .match_flag (match_flag),
        .ovf_flag   (ovf_flag),
        .cmp_next   (cmp_next)
    );

    // Output flip-flop and match detection
    pwm_outstage #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_en),
        .len_valid (len_valid),
        .cmp_en    (cmp_en),
        .ovf_evt   (ovf_evt),
        .next_low  (next_low),
        .cmp_next  (cmp_next),
        .match_evt (match_evt),
        .pwm_out   (pwm_out)
    );
endmodule

// File: rtl/pwm_reload_chan_chk.sv
// Module: pwm_reload_chan_chk
// Property checker for pwm_reload_chan. Bound to the top module below.
module pwm_reload_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic       pwm_out,
    input logic       match_flag,
    input logic       ovf_flag,
    input logic       match_evt,
    input logic       ovf_evt,
    input logic       cmp_en,
    input logic       match_ie,
    input logic [1:0] len_sel
);
    // R4
    rise_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(match_evt));

    // R4
    fall_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> ($past(ovf_evt) || !$past(cmp_en) || ($past(len_sel) == 2'b00)));

    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmp_en) |-> !pwm_out);

    // R8
    match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(match_evt && match_ie) |-> match_flag);

    // R9
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_evt) |-> ovf_flag);

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_sel == 2'b00) |-> (!ovf_evt && !match_evt));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cnt_en) && $past(cmp_en) && ($past(len_sel) != 2'b00))
        |-> $stable(pwm_out));
endmodule

bind pwm_reload_chan pwm_reload_chan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .pwm_out    (pwm_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag),
    .match_evt  (match_evt),
    .ovf_evt    (ovf_evt),
    .cmp_en     (cmp_en),
    .match_ie   (match_ie),
    .len_sel    (len_sel)
);

// File: tb/pwm_reload_chan_bench.sv
`timescale 1ns/1ps
module pwm_reload_chan_bench;
    logic       clk    = 1'b0;
    logic       rst_n  = 1'b0;
    logic       cnt_en = 1'b0;
    logic       wr_en  = 1'b0;
    logic [2:0] addr   = 3'd0;
    logic [7:0] wdata  = 8'd0;
    logic [7:0] rdata;
    logic       pwm_out;
    logic       match_flag;
    logic       ovf_flag;

    int         n_checks = 0;
    int         n_errors = 0;
    logic [1:0] cur_len  = 2'd0;
    logic       cur_mie  = 1'b0;

    always #5 clk = ~clk;

    pwm_reload_chan u_pwm_reload_chan (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out),
        .match_flag(match_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Control word: bank bit 7, length bits 5:4, match enable bit 3, flag keeps bits 1:0
    task automatic set_ctrl(input logic bank, input logic [1:0] len, input logic mie,
                            input logic keep_m, input logic keep_o);
        cur_len = len; cur_mie = mie;
        wr(3'd0, {bank, 1'b0, len, mie, 1'b0, keep_o, keep_m});
    endtask

    task automatic set_reload(input int c);
        set_ctrl(1'b1, cur_len, cur_mie, 1'b1, 1'b1);
        wr(3'd1, c[7:0]);
        wr(3'd2, c[15:8]);
    endtask

    task automatic sync_wrap();
        bit found = 0;
        set_ctrl(1'b1, cur_len, cur_mie, 1'b1, 1'b0);
        for (int k = 0; k < 5000; k++) begin
            if (ovf_flag) begin found = 1; break; end
            @(negedge clk);
        end
        chk("R9 wrap seen", int'(found), 1);
    endtask

    task automatic measure(input int len_bits, output int highs, output int first);
        highs = 0; first = -1;
        for (int i = 0; i < (1 << len_bits); i++) begin
            if (pwm_out) begin
                highs++;
                if (first < 0) first = i;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pwm_out", int'(pwm_out), 0);
        chk("R1 match_flag", int'(match_flag), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
        rd(3'd0, d); chk("R1 ctrl", int'(d), 0);
        rd(3'd1, d); chk("R1 val lo", int'(d), 0);
        rd(3'd2, d); chk("R1 val hi", int'(d), 0);
    endtask

    task automatic t_dual_map();
        logic [7:0] d;
        cnt_en = 1'b0;
        set_ctrl(1'b1, 2'd1, 1'b0, 1'b1, 1'b1);
        wr(3'd1, 8'h55); wr(3'd2, 8'h01);
        rd(3'd0, d); chk("R7 enable set by high byte", int'(d[2]), 1);
        set_ctrl(1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
        wr(3'd1, 8'hAA);
        rd(3'd0, d); chk("R7 enable cleared by low byte", int'(d[2]), 0);
        wr(3'd2, 8'hFE);
        rd(3'd1, d); chk("R6 live lo", int'(d), 8'hAA);
        rd(3'd2, d); chk("R6 live hi masked", int'(d), 8'h06);
        set_ctrl(1'b1, 2'd1, 1'b0, 1'b1, 1'b1);
        rd(3'd1, d); chk("R6 shadow lo", int'(d), 8'h55);
        rd(3'd2, d); chk("R6 shadow hi", int'(d), 8'h01);
    endtask

    task automatic t_reload();
        logic [7:0] d;
        logic       p0;
        // R12: no strobe, nothing moves
        p0 = pwm_out;
        repeat (700) @(negedge clk);
        chk("R12 output held", int'(pwm_out), int'(p0));
        chk("R12 no wrap without strobe", int'(ovf_flag), 0);
        cnt_en = 1'b1;
        for (int k = 0; k < 5000; k++) begin
            if (ovf_flag) break;
            @(negedge clk);
        end
        cnt_en = 1'b0;
        set_ctrl(1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
        rd(3'd1, d); chk("R5 reloaded lo", int'(d), 8'h55);
        rd(3'd2, d); chk("R5 reloaded hi", int'(d), 8'h01);
        cnt_en = 1'b1;
    endtask

    task automatic t_duty(input logic [1:0] len, input int c);
        int n, highs, first, exp_h, exp_f;
        n = 8 + int'(len);
        set_ctrl(1'b1, len, 1'b0, 1'b1, 1'b1);
        set_reload(c);
        sync_wrap();
        measure(n, highs, first);
        exp_h = (c >= (1 << n)) ? 0 : ((1 << n) - c);
        exp_f = (c >= (1 << n)) ? -1 : c;
        chk("R3 high count", highs, exp_h);
        chk("R4 rise position", first, exp_f);
    endtask

    task automatic t_period(input logic [1:0] len);
        logic prev;
        int   n;
        set_ctrl(1'b1, len, 1'b0, 1'b1, 1'b1);
        set_reload(5);
        prev = pwm_out;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
        n = 0; prev = pwm_out;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            n++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
        chk("R2 rise period", n, 1 << (8 + int'(len)));
    endtask

    task automatic t_enable();
        logic [7:0] d;
        int highs, first;
        set_ctrl(1'b1, 2'd1, 1'b1, 1'b1, 1'b1);
        set_reload(50);
        set_ctrl(1'b1, 2'd1, 1'b1, 1'b0, 1'b1);
        wr(3'd1, 8'd50);
        rd(3'd0, d); chk("R7 enable off", int'(d[2]), 0);
        repeat (2) @(negedge clk);
        measure(9, highs, first);
        chk("R7 output low while off", highs, 0);
        chk("R7 no match flag while off", int'(match_flag), 0);
        wr(3'd2, 8'd0);
        rd(3'd0, d); chk("R7 enable back on", int'(d[2]), 1);
        sync_wrap();
        measure(9, highs, first);
        chk("R7 duty after re-enable", highs, 512 - 50);
    endtask

    task automatic t_match();
        logic [7:0] d;
        set_ctrl(1'b1, 2'd1, 1'b0, 1'b0, 1'b1);
        set_reload(20);
        repeat (600) @(negedge clk);
        chk("R8 flag off when disabled", int'(match_flag), 0);
        set_ctrl(1'b1, 2'd1, 1'b1, 1'b1, 1'b1);
        repeat (600) @(negedge clk);
        chk("R8 flag set on rise", int'(match_flag), 1);
        cnt_en = 1'b0;
        set_ctrl(1'b1, 2'd1, 1'b1, 1'b1, 1'b1);
        chk("R10 writing 1 keeps match flag", int'(match_flag), 1);
        set_ctrl(1'b1, 2'd1, 1'b1, 1'b0, 1'b1);
        rd(3'd0, d); chk("R10 writing 0 clears match flag", int'(d[0]), 0);
        cnt_en = 1'b1;
    endtask

    task automatic t_ovf();
        cnt_en = 1'b0;
        set_ctrl(1'b1, 2'd1, 1'b0, 1'b1, 1'b0);
        chk("R10 overflow flag cleared", int'(ovf_flag), 0);
        cnt_en = 1'b1;
        repeat (520) @(negedge clk);
        chk("R9 overflow flag set", int'(ovf_flag), 1);
        cnt_en = 1'b0;
        set_ctrl(1'b1, 2'd1, 1'b0, 1'b1, 1'b1);
        chk("R10 writing 1 keeps overflow flag", int'(ovf_flag), 1);
        set_ctrl(1'b1, 2'd1, 1'b0, 1'b1, 1'b0);
        chk("R10 writing 0 clears overflow flag", int'(ovf_flag), 0);
        cnt_en = 1'b1;
    endtask

    task automatic t_idle();
        logic [7:0] d;
        int highs;
        set_ctrl(1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
        set_ctrl(1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        wr(3'd1, 8'h33); wr(3'd2, 8'h00);
        set_ctrl(1'b1, 2'd0, 1'b1, 1'b1, 1'b1);
        wr(3'd1, 8'h44); wr(3'd2, 8'h00);
        highs = 0;
        for (int i = 0; i < 3000; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
        chk("R11 output low when idle", highs, 0);
        chk("R11 no match flag when idle", int'(match_flag), 0);
        chk("R11 no overflow flag when idle", int'(ovf_flag), 0);
        set_ctrl(1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
        rd(3'd1, d); chk("R11 no reload when idle", int'(d), 8'h33);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dual_map();
        t_reload();
        t_duty(2'd1, 100);
        t_duty(2'd2, 0);
        t_duty(2'd3, 2047);
        t_duty(2'd1, 511);
        t_duty(2'd1, 512);
        t_duty(2'd2, 512);
        t_period(2'd1);
        t_period(2'd2);
        t_period(2'd3);
        t_enable();
        t_match();
        t_ovf();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule